// File: doc/BRIEF.md
# Trap Return Commit Unit

This unit carries out the two trap-return instructions of a hart with three privilege levels and an optional hypervisor layer. When a return request arrives, it checks whether the return is legal. If it is not, it reports an exception with a cause code. If it is, it pops the interrupt-enable and previous-privilege stack of the selected level, selects the return address, and produces the privilege level and virtualization flag the hart runs in afterwards.

The surrounding pipeline drives the current privilege, the virtualization flag, the relevant status bits and both saved exception PCs. It also drives two configuration bits: one says whether 16-bit instructions are supported, the other whether any memory-protection rule is set up. The unit answers one clock later with either a commit strobe carrying the new state or an exception strobe carrying a cause. When the restored virtualization flag comes from a saved previous-virtualization bit that was set, the unit also pulses a strobe that swaps the banked register sets. The registers themselves and the fetch redirect are handled outside this unit.

Top module: `xret_commit`

## Requirements
- R1: A supervisor return (req_mret_i=0) issued at user privilege (encoding 0) raises an exception with cause 2 (illegal instruction).
- R2: A machine return (req_mret_i=1) issued below machine privilege (encoding 3; supervisor is 1) raises cause 2.
- R3: When cfg_compressed_i is 0 and bits [1:0] of the selected return PC (sepc for a supervisor return, mepc for a machine return) are nonzero, cause 0 (misaligned fetch) is raised. When cfg_compressed_i is 1, the same PC commits.
- R4: A supervisor return at supervisor privilege with st_tsr_i set raises cause 2. With the hypervisor present, a supervisor return in virtual mode with hy_vtsr_i set raises cause 22 (virtual instruction).
- R5: A committed supervisor return sets SIE to the old SPIE, sets SPIE to 1, clears SPP, sets the privilege to the old SPP, and returns sepc_i.
- R6: With the hypervisor present and virtualization off, a committed supervisor return sets the new virtualization flag to the old SPV and clears SPV. It pulses swap_o exactly when the old SPV was 1.
- R7: A committed machine return sets MIE to the old MPIE, sets MPIE to 1, sets MPP to 0, clears MPV, sets the privilege to the old MPP, and returns mepc_i.
- R8: A machine return with cfg_prot_rules_i at 0 and an old MPP other than 3 raises cause 2.
- R9: With the hypervisor present, a committed machine return sets the virtualization flag to the old MPV and pulses swap_o exactly when the old MPV was 1.
- R10: On an exception, every new_* output equals the corresponding input, and commit_o and swap_o stay 0. The checks have a fixed priority: privilege check first, then alignment, then the trap bit, then the protection rule or the virtual trap bit. The first check that fails sets the cause.
- R11: Results appear on the outputs one clock after the request. commit_o, exc_o and swap_o are single-cycle strobes and are 0 when there is no request. Reset leaves new_priv_o at 3 with every strobe 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Return request this cycle |
| req_mret_i | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| cur_virt_i | input | 1 | Current virtualization flag |
| cfg_compressed_i | input | 1 | 16-bit instructions supported |
| cfg_prot_rules_i | input | 1 | At least one protection rule configured |
| st_sie_i | input | 1 | Supervisor interrupt enable |
| st_spie_i | input | 1 | Supervisor previous interrupt enable |
| st_spp_i | input | 1 | Supervisor previous privilege |
| st_mie_i | input | 1 | Machine interrupt enable |
| st_mpie_i | input | 1 | Machine previous interrupt enable |
| st_mpp_i | input | 2 | Machine previous privilege |
| st_mpv_i | input | 1 | Machine previous virtualization |
| st_tsr_i | input | 1 | Trap supervisor return |
| hy_spv_i | input | 1 | Hypervisor saved previous virtualization |
| hy_vtsr_i | input | 1 | Trap supervisor return in virtual mode |
| sepc_i | input | XLEN | Supervisor saved exception PC |
| mepc_i | input | XLEN | Machine saved exception PC |
| commit_o | output | 1 | Return committed |
| new_priv_o | output | 2 | New privilege |
| new_virt_o | output | 1 | New virtualization flag |
| new_sie_o | output | 1 | New SIE |
| new_spie_o | output | 1 | New SPIE |
| new_spp_o | output | 1 | New SPP |
| new_mie_o | output | 1 | New MIE |
| new_mpie_o | output | 1 | New MPIE |
| new_mpp_o | output | 2 | New MPP |
| new_mpv_o | output | 1 | New MPV |
| new_spv_o | output | 1 | New SPV |
| ret_pc_o | output | XLEN | Return address, valid with commit_o |
| swap_o | output | 1 | Banked register swap strobe |
| exc_o | output | 1 | Exception strobe |
| exc_cause_o | output | 5 | Exception cause |

## Verification
Every result passes through one register stage, so a wrong legality decision shows up one clock after the request. It appears as exc_o and commit_o taking the wrong values, or as a wrong exc_cause_o. The priority cases make sure a cause raised too late in the order cannot hide behind another. A status bit that pops wrongly, or a state change that leaks through an exception, shows up on the new_* outputs in that same cycle. A swap strobe that is missing or extra, or that outlasts one cycle, is visible on swap_o at that point or on the next idle cycle.

// File: rtl/xret_pkg.sv
package xret_pkg;
   localparam int CAUSE_W = 5;
   localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
   localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
   localparam logic [CAUSE_W-1:0] CAUSE_VIRT     = 5'd22;

   localparam logic [1:0] PRIV_U = 2'd0;
   localparam logic [1:0] PRIV_S = 2'd1;
   localparam logic [1:0] PRIV_M = 2'd3;

   typedef struct packed {
      logic       sie;
      logic       spie;
      logic       spp;
      logic       mie;
      logic       mpie;
      logic [1:0] mpp;
      logic       mpv;
      logic       spv;
   } xr_status_t;
endpackage

// File: rtl/xret_legality.sv
module xret_legality
   import xret_pkg::*;
#(
   parameter int HAS_HYP = 1
) (
   input  logic               is_mret,
   input  logic [1:0]         priv,
   input  logic               virt,
   input  logic               tsr,
   input  logic               vtsr,
   input  logic [1:0]         epc_low,
   input  logic               compressed,
   input  logic               prot_rules,
   input  logic [1:0]         mpp,
   output logic               exc,
   output logic [CAUSE_W-1:0] cause
);
   localparam bit HYP = (HAS_HYP != 0);

   always_comb begin
      exc   = 1'b1;
      cause = CAUSE_ILLEGAL;
      if (is_mret) begin
         if (priv != PRIV_M)                         cause = CAUSE_ILLEGAL;
         else if (!compressed && (epc_low != 2'b00)) cause = CAUSE_MISALIGN;
         else if (!prot_rules && (mpp != PRIV_M))    cause = CAUSE_ILLEGAL;
         else                                        exc   = 1'b0;
      end else begin
         if (priv == PRIV_U)                         cause = CAUSE_ILLEGAL;
         else if (!compressed && (epc_low != 2'b00)) cause = CAUSE_MISALIGN;
         else if (tsr && (priv != PRIV_M))           cause = CAUSE_ILLEGAL;
         else if (HYP && virt && vtsr)               cause = CAUSE_VIRT;
         else                                        exc   = 1'b0;
      end
   end
endmodule

// File: rtl/xret_sret_pop.sv
module xret_sret_pop
   import xret_pkg::*;
#(
   parameter int HAS_HYP = 1
) (
   input  xr_status_t st,
   input  logic       virt,
   output xr_status_t st_n,
   output logic [1:0] priv_n,
   output logic       virt_n,
   output logic       swap
);
   xr_status_t base;

   always_comb begin
      base      = st;
      base.sie  = st.spie;
      base.spie = 1'b1;
      base.spp  = 1'b0;
      priv_n    = {1'b0, st.spp};
   end

   generate
      if (HAS_HYP != 0) begin : g_hyp
         always_comb begin
            st_n = base;
            if (!virt) begin
               st_n.spv = 1'b0;
               virt_n   = st.spv;
               swap     = st.spv;
            end else begin
               virt_n   = virt;
               swap     = 1'b0;
            end
         end
      end else begin : g_plain
         always_comb begin
            st_n   = base;
            virt_n = virt;
            swap   = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/xret_mret_pop.sv
module xret_mret_pop
   import xret_pkg::*;
#(
   parameter int HAS_HYP = 1
) (
   input  xr_status_t st,
   input  logic       virt,
   output xr_status_t st_n,
   output logic [1:0] priv_n,
   output logic       virt_n,
   output logic       swap
);
   always_comb begin
      st_n      = st;
      st_n.mie  = st.mpie;
      st_n.mpie = 1'b1;
      st_n.mpp  = PRIV_U;
      st_n.mpv  = 1'b0;
      priv_n    = st.mpp;
   end

   generate
      if (HAS_HYP != 0) begin : g_hyp
         assign virt_n = st.mpv;
         assign swap   = st.mpv;
      end else begin : g_plain
         assign virt_n = virt;
         assign swap   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/xret_commit.sv
module xret_commit
   import xret_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int HAS_HYP = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid_i,
   input  logic               req_mret_i,
   input  logic [1:0]         cur_priv_i,
   input  logic               cur_virt_i,
   input  logic               cfg_compressed_i,
   input  logic               cfg_prot_rules_i,
   input  logic               st_sie_i,
   input  logic               st_spie_i,
   input  logic               st_spp_i,
   input  logic               st_mie_i,
   input  logic               st_mpie_i,
   input  logic [1:0]         st_mpp_i,
   input  logic               st_mpv_i,
   input  logic               st_tsr_i,
   input  logic               hy_spv_i,
   input  logic               hy_vtsr_i,
   input  logic [XLEN-1:0]    sepc_i,
   input  logic [XLEN-1:0]    mepc_i,
   output logic               commit_o,
   output logic [1:0]         new_priv_o,
   output logic               new_virt_o,
   output logic               new_sie_o,
   output logic               new_spie_o,
   output logic               new_spp_o,
   output logic               new_mie_o,
   output logic               new_mpie_o,
   output logic [1:0]         new_mpp_o,
   output logic               new_mpv_o,
   output logic               new_spv_o,
   output logic [XLEN-1:0]    ret_pc_o,
   output logic               swap_o,
   output logic               exc_o,
   output logic [CAUSE_W-1:0] exc_cause_o
);
   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("xret_commit: XLEN must be 32 or 64");
      end
      if (HAS_HYP < 0 || HAS_HYP > 1) begin : g_bad_hyp
         $error("xret_commit: HAS_HYP must be 0 or 1");
      end
   endgenerate

   xr_status_t        st_in, st_s, st_m, st_q;
   logic [1:0]        priv_s, priv_m, priv_q;
   logic              virt_s, virt_m, virt_q;
   logic              swap_s, swap_m;
   logic              chk_exc;
   logic [CAUSE_W-1:0] chk_cause;
   logic [XLEN-1:0]   epc_sel;

   assign st_in   = '{sie: st_sie_i, spie: st_spie_i, spp: st_spp_i,
                      mie: st_mie_i, mpie: st_mpie_i, mpp: st_mpp_i,
                      mpv: st_mpv_i, spv: hy_spv_i};
   assign epc_sel = req_mret_i ? mepc_i : sepc_i;

   xret_legality #(.HAS_HYP(HAS_HYP)) i_legal (
      .is_mret    (req_mret_i),
      .priv       (cur_priv_i),
      .virt       (cur_virt_i),
      .tsr        (st_tsr_i),
      .vtsr       (hy_vtsr_i),
      .epc_low    (epc_sel[1:0]),
      .compressed (cfg_compressed_i),
      .prot_rules (cfg_prot_rules_i),
      .mpp        (st_mpp_i),
      .exc        (chk_exc),
      .cause      (chk_cause)
   );

   xret_sret_pop #(.HAS_HYP(HAS_HYP)) i_spop (
      .st (st_in), .virt (cur_virt_i),
      .st_n (st_s), .priv_n (priv_s), .virt_n (virt_s), .swap (swap_s)
   );

   xret_mret_pop #(.HAS_HYP(HAS_HYP)) i_mpop (
      .st (st_in), .virt (cur_virt_i),
      .st_n (st_m), .priv_n (priv_m), .virt_n (virt_m), .swap (swap_m)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         commit_o    <= 1'b0;
         exc_o       <= 1'b0;
         swap_o      <= 1'b0;
         exc_cause_o <= '0;
         st_q        <= '0;
         priv_q      <= PRIV_M;
         virt_q      <= 1'b0;
         ret_pc_o    <= '0;
      end else begin
         commit_o <= req_valid_i && !chk_exc;
         exc_o    <= req_valid_i && chk_exc;
         swap_o   <= req_valid_i && !chk_exc && (req_mret_i ? swap_m : swap_s);
         if (req_valid_i) begin
            exc_cause_o <= chk_exc ? chk_cause : '0;
            ret_pc_o    <= epc_sel;
            if (chk_exc) begin
               st_q   <= st_in;
               priv_q <= cur_priv_i;
               virt_q <= cur_virt_i;
            end else if (req_mret_i) begin
               st_q   <= st_m;
               priv_q <= priv_m;
               virt_q <= virt_m;
            end else begin
               st_q   <= st_s;
               priv_q <= priv_s;
               virt_q <= virt_s;
            end
         end
      end
   end

   assign new_priv_o = priv_q;
   assign new_virt_o = virt_q;
   assign new_sie_o  = st_q.sie;
   assign new_spie_o = st_q.spie;
   assign new_spp_o  = st_q.spp;
   assign new_mie_o  = st_q.mie;
   assign new_mpie_o = st_q.mpie;
   assign new_mpp_o  = st_q.mpp;
   assign new_mpv_o  = st_q.mpv;
   assign new_spv_o  = st_q.spv;
endmodule

// File: rtl/xret_commit_chk.sv
module xret_commit_chk
   import xret_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid_i,
   input logic               req_mret_i,
   input logic [1:0]         cur_priv_i,
   input logic               commit_o,
   input logic               exc_o,
   input logic [CAUSE_W-1:0] exc_cause_o,
   input logic               swap_o,
   input logic               new_virt_o,
   input logic [1:0]         new_mpp_o,
   input logic               new_mpie_o,
   input logic               new_mpv_o
);
   // R1
   sret_user_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i && !req_mret_i && cur_priv_i == PRIV_U |=> exc_o && exc_cause_o == CAUSE_ILLEGAL);

   // R2
   mret_low_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i && req_mret_i && cur_priv_i != PRIV_M |=> exc_o && exc_cause_o == CAUSE_ILLEGAL);

   // R7
   mret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o && $past(req_mret_i) |-> new_mpp_o == PRIV_U && new_mpie_o && !new_mpv_o);

   // R10
   exc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_o |-> !commit_o && !swap_o);

   // R6
   swap_virt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swap_o |-> commit_o && new_virt_o);

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid_i |=> !commit_o && !exc_o && !swap_o);

   // R11
   answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i |=> $onehot(commit_o ^ exc_o ? 2'b01 : 2'b11) && (commit_o != exc_o));
endmodule

bind xret_commit xret_commit_chk i_xret_commit_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid_i (req_valid_i),
   .req_mret_i  (req_mret_i),
   .cur_priv_i  (cur_priv_i),
   .commit_o    (commit_o),
   .exc_o       (exc_o),
   .exc_cause_o (exc_cause_o),
   .swap_o      (swap_o),
   .new_virt_o  (new_virt_o),
   .new_mpp_o   (new_mpp_o),
   .new_mpie_o  (new_mpie_o),
   .new_mpv_o   (new_mpv_o)
);

// File: tb/test_xret_commit.sv
`timescale 1ns/1ps
module test_xret_commit;
   localparam int XLEN = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid_i = 0, req_mret_i = 0;
   logic [1:0] cur_priv_i = 0;
   logic cur_virt_i = 0, cfg_compressed_i = 0, cfg_prot_rules_i = 1;
   logic st_sie_i = 0, st_spie_i = 0, st_spp_i = 0, st_mie_i = 0, st_mpie_i = 0;
   logic [1:0] st_mpp_i = 0;
   logic st_mpv_i = 0, st_tsr_i = 0, hy_spv_i = 0, hy_vtsr_i = 0;
   logic [XLEN-1:0] sepc_i = 0, mepc_i = 0;
   logic commit_o, new_virt_o, new_sie_o, new_spie_o, new_spp_o, new_mie_o;
   logic new_mpie_o, new_mpv_o, new_spv_o, swap_o, exc_o;
   logic [1:0] new_priv_o, new_mpp_o;
   logic [XLEN-1:0] ret_pc_o;
   logic [4:0] exc_cause_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #2.5ns clk = ~clk;

   xret_commit #(.XLEN(XLEN), .HAS_HYP(1)) i_xret_commit (.*);

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic defaults();
      req_mret_i = 0; cur_priv_i = 2'd1; cur_virt_i = 0;
      cfg_compressed_i = 0; cfg_prot_rules_i = 1;
      st_sie_i = 0; st_spie_i = 0; st_spp_i = 0; st_mie_i = 0; st_mpie_i = 0;
      st_mpp_i = 0; st_mpv_i = 0; st_tsr_i = 0; hy_spv_i = 0; hy_vtsr_i = 0;
      sepc_i = 64'h8000_1000; mepc_i = 64'h8000_2000;
   endtask

   // one request, results sampled at the following falling edge
   task automatic fire();
      @(negedge clk);
      req_valid_i = 1;
      @(negedge clk);
      req_valid_i = 0;
   endtask

   task automatic expect_exc(input string tag, input logic [4:0] cause);
      chk({tag, " exc"}, exc_o, 1);
      chk({tag, " commit"}, commit_o, 0);
      chk({tag, " swap"}, swap_o, 0);
      chk({tag, " cause"}, exc_cause_o, cause);
   endtask

   // R10: state unchanged on exception
   task automatic expect_unchanged(input string tag);
      chk({tag, " R10 priv"}, new_priv_o, cur_priv_i);
      chk({tag, " R10 virt"}, new_virt_o, cur_virt_i);
      chk({tag, " R10 stat"}, {new_sie_o, new_spie_o, new_spp_o, new_mie_o, new_mpie_o,
                               new_mpp_o, new_mpv_o, new_spv_o},
          {st_sie_i, st_spie_i, st_spp_i, st_mie_i, st_mpie_i, st_mpp_i, st_mpv_i, hy_spv_i});
   endtask

   task automatic t_reset();
      chk("R11 reset commit", commit_o, 0);
      chk("R11 reset exc", exc_o, 0);
      chk("R11 reset swap", swap_o, 0);
      chk("R11 reset priv", new_priv_o, 2'd3);
   endtask

   task automatic t_r1_sret_user();
      defaults(); cur_priv_i = 0; st_spie_i = 1; st_spp_i = 1; hy_spv_i = 1;
      fire();
      expect_exc("R1", 5'd2);
      expect_unchanged("R1");
   endtask

   task automatic t_r2_mret_low();
      defaults(); req_mret_i = 1; cur_priv_i = 1; st_mpie_i = 1; st_mpp_i = 3; st_mpv_i = 1;
      fire();
      expect_exc("R2", 5'd2);
      expect_unchanged("R2");
   endtask

   task automatic t_r3_misalign();
      defaults(); sepc_i = 64'h8000_1002;
      fire();
      expect_exc("R3 sret", 5'd0);
      defaults(); req_mret_i = 1; cur_priv_i = 3; st_mpp_i = 3; mepc_i = 64'h8000_2001;
      fire();
      expect_exc("R3 mret", 5'd0);
      defaults(); sepc_i = 64'h8000_1002; cfg_compressed_i = 1;
      fire();
      chk("R3 compressed commit", commit_o, 1);
      chk("R3 compressed pc", ret_pc_o, 64'h8000_1002);
   endtask

   task automatic t_r10_priority();
      defaults(); cur_priv_i = 0; sepc_i = 64'h3;
      fire();
      chk("R10 priv beats align", exc_cause_o, 5'd2);
      defaults(); sepc_i = 64'h2; st_tsr_i = 1;
      fire();
      chk("R10 align beats tsr", exc_cause_o, 5'd0);
      defaults(); cur_virt_i = 1; st_tsr_i = 1; hy_vtsr_i = 1;
      fire();
      chk("R10 tsr beats vtsr", exc_cause_o, 5'd2);
   endtask

   task automatic t_r4_tsr();
      defaults(); st_tsr_i = 1;
      fire();
      expect_exc("R4 tsr", 5'd2);
      defaults(); cur_priv_i = 3; st_tsr_i = 1;
      fire();
      chk("R4 tsr at M commits", commit_o, 1);
      defaults(); cur_virt_i = 1; hy_vtsr_i = 1; st_spie_i = 1;
      fire();
      expect_exc("R4 vtsr", 5'd22);
      expect_unchanged("R4 vtsr");
   endtask

   task automatic t_r5_sret_pop();
      defaults(); cur_priv_i = 3; st_sie_i = 0; st_spie_i = 1; st_spp_i = 1; st_mie_i = 1;
      fire();
      chk("R5 commit", commit_o, 1);
      chk("R5 sie", new_sie_o, 1);
      chk("R5 spie", new_spie_o, 1);
      chk("R5 spp", new_spp_o, 0);
      chk("R5 priv", new_priv_o, 2'd1);
      chk("R5 pc", ret_pc_o, 64'h8000_1000);
      chk("R5 mie kept", new_mie_o, 1);
      defaults(); st_sie_i = 1; st_spie_i = 0; st_spp_i = 0;
      fire();
      chk("R5 sie from 0", new_sie_o, 0);
      chk("R5 priv user", new_priv_o, 2'd0);
   endtask

   task automatic t_r6_sret_hyp();
      defaults(); hy_spv_i = 1;
      fire();
      chk("R6 virt", new_virt_o, 1);
      chk("R6 spv cleared", new_spv_o, 0);
      chk("R6 swap", swap_o, 1);
      @(negedge clk);
      chk("R11 swap one cycle", swap_o, 0);
      chk("R11 commit one cycle", commit_o, 0);
      defaults(); hy_spv_i = 0;
      fire();
      chk("R6 no swap", swap_o, 0);
      chk("R6 virt off", new_virt_o, 0);
      defaults(); cur_virt_i = 1; hy_spv_i = 1;
      fire();
      chk("R6 virt on keeps spv", new_spv_o, 1);
      chk("R6 virt on no swap", swap_o, 0);
   endtask

   task automatic t_r7_mret_pop();
      defaults(); req_mret_i = 1; cur_priv_i = 3; st_mie_i = 1; st_mpie_i = 0;
      st_mpp_i = 1; st_sie_i = 1;
      fire();
      chk("R7 commit", commit_o, 1);
      chk("R7 mie", new_mie_o, 0);
      chk("R7 mpie", new_mpie_o, 1);
      chk("R7 mpp", new_mpp_o, 0);
      chk("R7 mpv", new_mpv_o, 0);
      chk("R7 priv", new_priv_o, 2'd1);
      chk("R7 pc", ret_pc_o, 64'h8000_2000);
      chk("R7 sie kept", new_sie_o, 1);
   endtask

   task automatic t_r8_prot();
      defaults(); req_mret_i = 1; cur_priv_i = 3; cfg_prot_rules_i = 0; st_mpp_i = 0;
      fire();
      expect_exc("R8 no rules", 5'd2);
      defaults(); req_mret_i = 1; cur_priv_i = 3; cfg_prot_rules_i = 0; st_mpp_i = 3;
      fire();
      chk("R8 mpp M commits", commit_o, 1);
      chk("R8 priv", new_priv_o, 2'd3);
   endtask

   task automatic t_r9_mret_virt();
      defaults(); req_mret_i = 1; cur_priv_i = 3; st_mpp_i = 1; st_mpv_i = 1;
      fire();
      chk("R9 virt", new_virt_o, 1);
      chk("R9 swap", swap_o, 1);
      chk("R9 mpv cleared", new_mpv_o, 0);
      defaults(); req_mret_i = 1; cur_priv_i = 3; st_mpp_i = 1; st_mpv_i = 0;
      fire();
      chk("R9 no swap", swap_o, 0);
      chk("R9 virt 0", new_virt_o, 0);
   endtask

   initial begin
      defaults();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      @(negedge clk);
      chk("R11 idle", {commit_o, exc_o, swap_o}, 3'b000);
      t_r1_sret_user();
      t_r2_mret_low();
      t_r3_misalign();
      t_r4_tsr();
      t_r5_sret_pop();
      t_r6_sret_hyp();
      t_r7_mret_pop();
      t_r8_prot();
      t_r9_mret_virt();
      t_r10_priority();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 5ns);
      if (!done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog act=hung exp=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule